// File: doc/BRIEF.md
# Snooped I/O-Port Byte Capture Queue

This block listens passively to a CPU bus. Each time the CPU writes to one decoded I/O port, an external decoder pulses an active-low port strobe. The block sees the end of that strobe and stores the byte on the data bus into a 256-entry circular queue. The block never drives the CPU bus while it captures.

A local consumer takes the bytes out with single-cycle pop requests. Every pop reports either a byte or an "empty" indication. The CPU-side producer needs flow control, so after each pop the block becomes a bus master for a short time. It writes its new read position into the CPU's memory, one byte below a configured base address. An initialisation command aligns the CPU's view of the queue. The block reads the producer's input index from two bytes below the base and copies it to the output-index byte one below the base. It then adopts that base for later write-backs. While the base is zero, no write-back takes place.

Top module: `snoopq_top`

## Requirements
- R1: Each rising edge of `snoop_cs_n` stores the byte on `snoop_data` at the write index, which then increments and wraps from 255 to 0. The byte must be held from the strobe low phase until 4 cycles after the rise. Capture runs whatever the consumer or the bus master is doing.
- R2: A `pop_req` sampled while the queue holds data gives `pop_ack`=1 and `pop_valid`=1 in the next cycle, with `pop_data` set to the oldest stored byte (first in, first out).
- R3: Each successful pop increments the 8-bit read count, which wraps from 255 to 0.
- R4: A `pop_req` sampled while the read count equals the write index gives `pop_ack`=1 and `pop_valid`=0 in the next cycle, and the read count does not change.
- R5: After a successful pop with a nonzero base, the block requests the bus. It performs one write (`bm_we`=1) of the read count, zero-extended, to address base-1, then releases the bus. With the base at zero, `bm_req` stays low.
- R6: A `cfg_init` pulse with `cfg_base`=B performs a read at B-2, then a write of the returned byte to B-1. B then becomes the base that later pops write back to.
- R7: `bm_stb` is high only while `bm_req` and `bm_gnt` are both high. `bm_stb`, `bm_addr`, `bm_we` and `bm_wdata` stay stable until `bm_ack`. `bm_req` falls after the last acknowledge, and is not raised again until `bm_gnt` has been seen low.
- R8: While `rst` is high, and in the cycle after, the read count, write index and base are zero, and `bm_req`, `bm_stb` and `pop_ack` are low.
- R9: The queue keeps no full flag. After 256 captures with no pop, a pop reports empty. A further capture then becomes poppable with that new byte.
- R10: Pops made while a bus transaction is running are all accepted. A later write-back carries the latest read count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| snoop_cs_n | input | 1 | Decoded I/O-port write strobe, active low, asynchronous |
| snoop_data | input | DATA_W | Snooped CPU data bus |
| pop_req | input | 1 | Pop request, one cycle per pop |
| pop_ack | output | 1 | Pop answered (one cycle after the request) |
| pop_valid | output | 1 | 1: `pop_data` holds a byte; 0: queue was empty |
| pop_data | output | DATA_W | Popped byte |
| cfg_init | input | 1 | Start initialisation with `cfg_base` |
| cfg_base | input | ADDR_W | Base address of the CPU-side queue |
| bm_req | output | 1 | Bus request to the CPU |
| bm_gnt | input | 1 | Bus grant from the CPU |
| bm_stb | output | 1 | Bus-master access strobe |
| bm_we | output | 1 | 1 write, 0 read |
| bm_addr | output | ADDR_W | Bus-master address |
| bm_wdata | output | DATA_W | Bus-master write data |
| bm_rdata | input | DATA_W | Bus-master read data, valid with `bm_ack` |
| bm_ack | input | 1 | Access acknowledge |

## Verification
The checker asserts on every cycle:
- the index advance after each capture edge and each pop;
- the empty-pop answer;
- the bus handshake rules (strobe only under grant, stable until acknowledge);
- the reset state.

Other behaviour appears only in the bench's scenarios, which check it against a reference queue and a bus-slave model:
- the stored byte order;
- the write-back address and value;
- the read-then-write sequence of initialisation;
- the silent behaviour with a zero base;
- the overrun in which a full ring reads as empty;
- the coalescing of pops that arrive during a transaction.

// File: rtl/snoopq_pkg.sv
package snoopq_pkg;
  typedef enum logic [2:0] {
    WB_IDLE,
    WB_REQ,
    WB_RD,
    WB_WR,
    WB_REL
  } wb_state_e;
endpackage

// File: rtl/snoopq_edge.sv
module snoopq_edge #(
  parameter int DATA_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [DATA_W-1:0] data,
  output logic              cap_evt,
  output logic [DATA_W-1:0] cap_data
);
  logic [STAGES:0]   sh_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-1:0], cs_n};
  end

  always_ff @(posedge clk) data_q <= data;

  assign cap_evt  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign cap_data = data_q;
endmodule

// File: rtl/snoopq_ring.sv
module snoopq_ring #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop_req,
  output logic              pop_ack,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_ok,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  wr_idx
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  wr_q, rd_q;
  logic              fire;

  assign fire = pop_req && (rd_q != wr_q);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (fire) pop_data <= mem[rd_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q      <= '0;
      rd_q      <= '0;
      pop_ack   <= 1'b0;
      pop_valid <= 1'b0;
    end else begin
      if (wr_en) wr_q <= wr_q + 1'b1;
      if (fire)  rd_q <= rd_q + 1'b1;
      pop_ack   <= pop_req;
      pop_valid <= fire;
    end
  end

  assign pop_ok = fire;
  assign rd_idx = rd_q;
  assign wr_idx = wr_q;
endmodule

// File: rtl/snoopq_wb.sv
module snoopq_wb
  import snoopq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pop_ok,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              cfg_init,
  input  logic [ADDR_W-1:0] cfg_base,
  output logic              bm_req,
  input  logic              bm_gnt,
  output logic              bm_stb,
  output logic              bm_we,
  output logic [ADDR_W-1:0] bm_addr,
  output logic [DATA_W-1:0] bm_wdata,
  input  logic [DATA_W-1:0] bm_rdata,
  input  logic              bm_ack,
  output logic [ADDR_W-1:0] base
);
  localparam logic [ADDR_W-1:0] OUT_OFS = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IN_OFS  = ADDR_W'(2);

  wb_state_e         st_q;
  logic              wb_pend, init_pend, op_init;
  logic [ADDR_W-1:0] init_base, cur_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= WB_IDLE;
      wb_pend   <= 1'b0;
      init_pend <= 1'b0;
      op_init   <= 1'b0;
      init_base <= '0;
      cur_base  <= '0;
      base      <= '0;
      bm_req    <= 1'b0;
      bm_stb    <= 1'b0;
      bm_we     <= 1'b0;
      bm_addr   <= '0;
      bm_wdata  <= '0;
    end else begin
      case (st_q)
        WB_IDLE: begin
          if (init_pend) begin
            init_pend <= 1'b0;
            op_init   <= 1'b1;
            cur_base  <= init_base;
            bm_req    <= 1'b1;
            st_q      <= WB_REQ;
          end else if (wb_pend) begin
            wb_pend <= 1'b0;
            if (base != '0) begin
              op_init  <= 1'b0;
              cur_base <= base;
              bm_req   <= 1'b1;
              st_q     <= WB_REQ;
            end
          end
        end
        WB_REQ: begin
          if (bm_gnt) begin
            bm_stb <= 1'b1;
            if (op_init) begin
              bm_we   <= 1'b0;
              bm_addr <= cur_base - IN_OFS;
              st_q    <= WB_RD;
            end else begin
              bm_we    <= 1'b1;
              bm_addr  <= cur_base - OUT_OFS;
              bm_wdata <= DATA_W'(rd_idx);
              st_q     <= WB_WR;
            end
          end
        end
        WB_RD: begin
          if (bm_ack) begin
            bm_we    <= 1'b1;
            bm_addr  <= cur_base - OUT_OFS;
            bm_wdata <= bm_rdata;
            st_q     <= WB_WR;
          end
        end
        WB_WR: begin
          if (bm_ack) begin
            bm_stb <= 1'b0;
            bm_we  <= 1'b0;
            bm_req <= 1'b0;
            if (op_init) base <= cur_base;
            st_q   <= WB_REL;
          end
        end
        WB_REL: begin
          if (!bm_gnt) st_q <= WB_IDLE;
        end
        default: st_q <= WB_IDLE;
      endcase
      if (pop_ok) wb_pend <= 1'b1;
      if (cfg_init) begin
        init_pend <= 1'b1;
        init_base <= cfg_base;
      end
    end
  end
endmodule

// File: rtl/snoopq_top.sv
module snoopq_top #(
  parameter int DATA_W      = 8,
  parameter int IDX_W       = 8,
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snoop_cs_n,
  input  logic [DATA_W-1:0] snoop_data,
  input  logic              pop_req,
  output logic              pop_ack,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  input  logic              cfg_init,
  input  logic [ADDR_W-1:0] cfg_base,
  output logic              bm_req,
  input  logic              bm_gnt,
  output logic              bm_stb,
  output logic              bm_we,
  output logic [ADDR_W-1:0] bm_addr,
  output logic [DATA_W-1:0] bm_wdata,
  input  logic [DATA_W-1:0] bm_rdata,
  input  logic              bm_ack
);
  logic              cap_evt;
  logic [DATA_W-1:0] cap_data;
  logic              pop_ok;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [ADDR_W-1:0] base;

  snoopq_edge #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .cs_n(snoop_cs_n), .data(snoop_data),
    .cap_evt(cap_evt), .cap_data(cap_data)
  );

  snoopq_ring #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst(rst), .wr_en(cap_evt), .wr_data(cap_data),
    .pop_req(pop_req), .pop_ack(pop_ack), .pop_valid(pop_valid),
    .pop_data(pop_data), .pop_ok(pop_ok), .rd_idx(rd_idx), .wr_idx(wr_idx)
  );

  snoopq_wb #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_wb (
    .clk(clk), .rst(rst), .pop_ok(pop_ok), .rd_idx(rd_idx),
    .cfg_init(cfg_init), .cfg_base(cfg_base),
    .bm_req(bm_req), .bm_gnt(bm_gnt), .bm_stb(bm_stb), .bm_we(bm_we),
    .bm_addr(bm_addr), .bm_wdata(bm_wdata), .bm_rdata(bm_rdata),
    .bm_ack(bm_ack), .base(base)
  );
endmodule

// File: rtl/snoopq_chk.sv
module snoopq_chk #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              pop_req,
  input logic              pop_ack,
  input logic              pop_valid,
  input logic              cap_evt,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [ADDR_W-1:0] base,
  input logic              bm_req,
  input logic              bm_gnt,
  input logic              bm_stb,
  input logic              bm_we,
  input logic [ADDR_W-1:0] bm_addr,
  input logic [DATA_W-1:0] bm_wdata,
  input logic              bm_ack
);
  p_cap_adv_r1: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> wr_idx == $past(wr_idx) + 1'b1);

  p_pop_data_r2: assert property (@(posedge clk) disable iff (rst)
    (pop_req && rd_idx != wr_idx) |=> (pop_ack && pop_valid));

  p_rd_adv_r3: assert property (@(posedge clk) disable iff (rst)
    (pop_req && rd_idx != wr_idx) |=> rd_idx == $past(rd_idx) + 1'b1);

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (pop_req && rd_idx == wr_idx) |=> (pop_ack && !pop_valid && rd_idx == $past(rd_idx)));

  p_stb_gnt_r7: assert property (@(posedge clk) disable iff (rst)
    bm_stb |-> (bm_req && bm_gnt));

  p_stb_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (bm_stb && !bm_ack) |=> (bm_stb && $stable(bm_addr) && $stable(bm_we) && $stable(bm_wdata)));

  p_req_after_gnt_low_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(bm_req) |-> !bm_gnt);

  p_reset_r8: assert property (@(posedge clk)
    rst |=> (rd_idx == '0 && wr_idx == '0 && base == '0 && !bm_req && !bm_stb && !pop_ack));
endmodule

bind snoopq_top snoopq_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .pop_req(pop_req), .pop_ack(pop_ack), .pop_valid(pop_valid),
  .cap_evt(cap_evt), .rd_idx(rd_idx), .wr_idx(wr_idx), .base(base),
  .bm_req(bm_req), .bm_gnt(bm_gnt), .bm_stb(bm_stb), .bm_we(bm_we),
  .bm_addr(bm_addr), .bm_wdata(bm_wdata), .bm_ack(bm_ack)
);

// File: tb/test_snoopq_top.sv
module test_snoopq_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 8;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              snoop_cs_n = 1'b1;
  logic [DATA_W-1:0] snoop_data = '0;
  logic              pop_req = 1'b0;
  logic              pop_ack, pop_valid;
  logic [DATA_W-1:0] pop_data;
  logic              cfg_init = 1'b0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic              bm_req, bm_stb, bm_we;
  logic              bm_gnt = 1'b0;
  logic              bm_ack = 1'b0;
  logic [ADDR_W-1:0] bm_addr;
  logic [DATA_W-1:0] bm_wdata;
  logic [DATA_W-1:0] bm_rdata = '0;

  snoopq_top #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) i_snoopq_top (
    .clk(clk), .rst(rst), .snoop_cs_n(snoop_cs_n), .snoop_data(snoop_data),
    .pop_req(pop_req), .pop_ack(pop_ack), .pop_valid(pop_valid), .pop_data(pop_data),
    .cfg_init(cfg_init), .cfg_base(cfg_base),
    .bm_req(bm_req), .bm_gnt(bm_gnt), .bm_stb(bm_stb), .bm_we(bm_we),
    .bm_addr(bm_addr), .bm_wdata(bm_wdata), .bm_rdata(bm_rdata), .bm_ack(bm_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // bus-slave model state
  logic [DATA_W-1:0] remote_in = 8'h5A;
  int n_bus_wr = 0, n_bus_rd = 0, proto_err = 0;
  logic [ADDR_W-1:0] last_waddr = '0, last_raddr = '0;
  logic [DATA_W-1:0] last_wdata = '0;

  // reference queue
  logic [DATA_W-1:0] ref_mem [256];
  logic [IDX_W-1:0]  ref_wr = '0, ref_rd = '0;
  logic [ADDR_W-1:0] ref_base = '0;

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
    return IDX_W'((int'(i) + 1) % 256);
  endfunction

  function automatic logic [ADDR_W-1:0] out_addr(input logic [ADDR_W-1:0] b);
    return b - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] in_addr(input logic [ADDR_W-1:0] b);
    return b - ADDR_W'(2);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (bm_stb && !bm_gnt) proto_err++;
      if (bm_stb && !bm_ack) begin
        if (bm_we) begin
          n_bus_wr++;
          last_waddr = bm_addr;
          last_wdata = bm_wdata;
        end else begin
          n_bus_rd++;
          last_raddr = bm_addr;
        end
      end
      bm_gnt   <= bm_req;
      bm_ack   <= bm_stb && !bm_ack;
      bm_rdata <= remote_in;
    end
  end

  task automatic cs_write(input logic [DATA_W-1:0] b);
    @(negedge clk);
    snoop_data = b;
    snoop_cs_n = 1'b0;
    repeat (2) @(negedge clk);
    snoop_cs_n = 1'b1;
    repeat (5) @(negedge clk);
    ref_mem[ref_wr] = b;
    ref_wr = next_idx(ref_wr);
  endtask

  task automatic do_pop(output logic v, output logic [DATA_W-1:0] d, output logic a);
    @(negedge clk);
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    v = pop_valid;
    d = pop_data;
    a = pop_ack;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (bm_req || bm_gnt) @(negedge clk);
  endtask

  // pop, compare with reference, check write-back if base is set
  task automatic pop_check(input bit settle);
    logic v, a;
    logic [DATA_W-1:0] d;
    int wr0;
    wr0 = n_bus_wr;
    do_pop(v, d, a);
    if (ref_rd != ref_wr) begin
      chk(a && v, "R2 pop_valid", int'(v), 1);
      chk(d == ref_mem[ref_rd], "R2 pop_data", int'(d), int'(ref_mem[ref_rd]));
      ref_rd = next_idx(ref_rd);
      if (settle) begin
        wait_idle();
        if (ref_base != '0) begin
          chk(last_waddr == out_addr(ref_base), "R5 wb addr", int'(last_waddr), int'(out_addr(ref_base)));
          if (ref_rd == '0)
            chk(last_wdata == 8'h00, "R3 wrap wb value", int'(last_wdata), 0);
          else
            chk(last_wdata == DATA_W'(ref_rd), "R5 wb value", int'(last_wdata), int'(ref_rd));
        end else begin
          chk(n_bus_wr == wr0, "R5 base zero no write", n_bus_wr, wr0);
        end
      end
    end else begin
      chk(a && !v, "R4 empty pop", int'({a, v}), 2);
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    logic v, a;
    logic [DATA_W-1:0] d;
    int rd0, wr0;
    unused_seed = $urandom(32'h0000_2F17);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(!bm_req && !bm_stb && !pop_ack, "R8 reset outputs", int'({bm_req, bm_stb, pop_ack}), 0);

    // R4 empty pop right after reset
    pop_check(1'b1);

    // R1 / R2 directed, base zero (R5 quiet)
    cs_write(8'hA1);
    cs_write(8'h00);
    cs_write(8'hFF);
    for (int i = 0; i < 3; i++) pop_check(1'b1);
    chk(n_bus_wr == 0 && n_bus_rd == 0, "R5 no bus with base zero", n_bus_wr + n_bus_rd, 0);
    pop_check(1'b1);

    // R6 initialisation
    rd0 = n_bus_rd;
    wr0 = n_bus_wr;
    @(negedge clk);
    cfg_base = 16'h1234;
    cfg_init = 1'b1;
    @(negedge clk);
    cfg_init = 1'b0;
    wait_idle();
    ref_base = 16'h1234;
    chk(n_bus_rd == rd0 + 1, "R6 one read", n_bus_rd, rd0 + 1);
    chk(last_raddr == in_addr(ref_base), "R6 read addr", int'(last_raddr), int'(in_addr(ref_base)));
    chk(n_bus_wr == wr0 + 1, "R6 one write", n_bus_wr, wr0 + 1);
    chk(last_waddr == out_addr(ref_base) && last_wdata == remote_in, "R6 copy in->out",
        int'(last_wdata), int'(remote_in));

    // R6 later pops use the new base
    cs_write(8'h3C);
    pop_check(1'b1);

    // R1 capture during bus activity, R10 coalescing
    cs_write(8'h11);
    cs_write(8'h22);
    cs_write(8'h33);
    pop_check(1'b0);
    cs_write(8'h44);
    pop_check(1'b0);
    pop_check(1'b0);
    wait_idle();
    chk(last_wdata == DATA_W'(ref_rd), "R10 latest count written", int'(last_wdata), int'(ref_rd));
    pop_check(1'b1);
    chk(proto_err == 0, "R7 strobe only under grant", proto_err, 0);

    // constrained random
    for (int it = 0; it < 260; it++) begin
      int np, nq, occ;
      occ = (int'(ref_wr) - int'(ref_rd) + 256) % 256;
      np = $urandom_range(0, 3);
      if (occ + np > 200) np = 0;
      for (int k = 0; k < np; k++) cs_write(DATA_W'($urandom_range(0, 255)));
      nq = $urandom_range(0, 3);
      for (int k = 0; k < nq; k++) pop_check(1'b1);
    end
    while (ref_rd != ref_wr) pop_check(1'b1);
    pop_check(1'b1);
    chk(proto_err == 0, "R7 protocol after random", proto_err, 0);

    // R9 overrun: 256 captures make the ring look empty
    for (int k = 0; k < 256; k++) cs_write(DATA_W'(k ^ 8'h5F));
    do_pop(v, d, a);
    chk(a && !v, "R9 full ring reads empty", int'({a, v}), 2);
    cs_write(8'hC7);
    ref_rd = ref_wr - 1'b1;
    ref_mem[ref_rd] = 8'hC7;
    do_pop(v, d, a);
    chk(v && d == 8'hC7, "R9 byte after overrun", int'(d), 'hC7);
    ref_rd = ref_wr;
    wait_idle();

    // R8 reset again clears counts
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cs_write(8'h9E);
    do_pop(v, d, a);
    chk(v && d == 8'h9E, "R8 ring restarts after reset", int'(d), 'h9E);
    wait_idle();
    chk(!bm_req, "R8 base cleared by reset", int'(bm_req), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule